// File: doc/BRIEF.md
# Interleaved DMA address generator

This block produces the byte-address stream for one interleaved transfer. A transfer is a frame, an ordered list of chunks, repeated a chosen number of times. Each chunk is a run of contiguous bytes followed by a gap. Software-side logic first loads a small chunk table through a write port, one entry per write, each entry holding a chunk length and a gap. It then pulses `start` with the two base addresses, a frame count, a chunk count and four per-side mode flags. For every byte beat the block presents a source and destination address pair on a valid/ready interface. After the last beat it pulses `done`.

Each side advances on its own. A side whose increment flag is clear keeps its base address for the whole transfer. A side that increments but does not scatter runs contiguously and ignores the gaps. A side that increments and scatters skips the chunk's gap after the chunk's last byte, and this includes the last chunk of a frame before the next frame begins.

The controller has three states. `ST_IDLE` accepts the start command. `ST_RUN` issues beats. `ST_FINISH` is the one-cycle done pulse. The named transitions are:
- GO: `ST_IDLE` to `ST_RUN`, on a start with nonzero work.
- SKIP: `ST_IDLE` to `ST_FINISH`, on a start with nothing to do.
- LAST_BEAT: `ST_RUN` to `ST_FINISH`, on the handshake of the final beat.
- RETIRE: `ST_FINISH` to `ST_IDLE`, unconditionally.

Top module: `ilv_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, `beat_valid` and `done` are low.
- R2: `start` in idle captures `src_base` and `dst_base`, and the first beat carries exactly those addresses in the cycle after `start`.
- R3: Within a chunk, every handshake advances an incrementing side's address by exactly 1.
- R4: On a side with increment and scatter both set, the handshake on a chunk's last byte advances the address by 1 plus that chunk's gap. This applies to the last chunk of a frame as well.
- R5: On a side with increment set and scatter clear, the gaps are ignored and the address advances by 1 on every handshake.
- R6: On a side with increment clear, the address stays at its base for the whole transfer, whatever that side's scatter flag is.
- R7: The table entries 0 to `num_chunks`-1 are walked in index order, and the frame repeats `num_frames` times. The beat count therefore equals `num_frames` times the sum of the used chunk lengths. A `num_chunks` above the table depth is clamped to the depth.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_valid` and both addresses hold steady.
- R9: `done` goes high for exactly one cycle, in the cycle after the final handshake. `beat_valid` is low in that cycle and after it.
- R10: A start with `num_frames` = 0, `num_chunks` = 0 or a zero length in any used entry raises `done` in the next cycle and emits no beat.
- R11: While a transfer runs, `start` and table writes are ignored. The running addresses are unaffected, and the table written before the run is still in place for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Chunk table write strobe (accepted only in idle) |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_len | input | LEN_W | Chunk length in bytes |
| tbl_gap | input | GAP_W | Gap following the chunk, in bytes |
| start | input | 1 | Start command (accepted only in idle) |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| num_frames | input | FRAME_W | Number of frame repetitions |
| num_chunks | input | CNT_W | Entries per frame |
| src_inc | input | 1 | Source address increments |
| dst_inc | input | 1 | Destination address increments |
| src_scat | input | 1 | Source applies gaps |
| dst_scat | input | 1 | Destination applies gaps |
| beat_valid | output | 1 | Address pair valid |
| beat_ready | input | 1 | Consumer accepts the pair |
| beat_src | output | ADDR_W | Source byte address |
| beat_dst | output | ADDR_W | Destination byte address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two situations are the hardest to reach from the ports.

The first is back-pressure that lands exactly on a chunk's last byte or on a frame's last byte, where the gap jump and the counter wrap must wait for the handshake. The bench drives `beat_ready` from an LFSR, so stalls fall on those boundaries across several vectors of different shapes. Its reference model advances only on the cycles in which it drove ready high.

The second is interference during a run. A directed run raises `start` with other base addresses and overwrites table entry 0 in the middle of a transfer. The run's addresses must stay on course. A following transfer, started without reloading the table, must still see the original entry.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } ilv_state_e;

endpackage

// File: rtl/ilv_chunk_table.sv
module ilv_chunk_table #(
    parameter int DEPTH = 4,
    parameter int LEN_W = 8,
    parameter int GAP_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [GAP_W-1:0] wr_gap,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [CNT_W-1:0] used_cnt,
    output logic [LEN_W-1:0] rd_len,
    output logic [GAP_W-1:0] rd_gap,
    output logic             any_zero
);

    logic [LEN_W-1:0] len_q [DEPTH];
    logic [GAP_W-1:0] gap_q [DEPTH];
    logic [DEPTH-1:0] zero_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                len_q[i] <= '0;
                gap_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    len_q[i] <= wr_len;
                    gap_q[i] <= wr_gap;
                end
            end
        end
    end

    // One zero-length detector per entry; only entries inside the frame count.
    for (genvar g = 0; g < DEPTH; g++) begin : g_zero
        assign zero_flag[g] = (CNT_W'(g) < used_cnt) && (len_q[g] == '0);
    end

    assign any_zero = |zero_flag;
    assign rd_len   = len_q[rd_idx];
    assign rd_gap   = gap_q[rd_idx];

endmodule

// File: rtl/ilv_addr_side.sv
module ilv_addr_side #(
    parameter int ADDR_W = 32,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              inc,
    input  logic              scat,
    input  logic              step,
    input  logic              chunk_end,
    input  logic [GAP_W-1:0]  gap,
    output logic [ADDR_W-1:0] addr,
    output logic              inc_q,
    output logic              scat_q
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride;

    // Scatter only matters while incrementing; the gap joins the stride at a chunk end.
    always_comb begin
        stride = ADDR_W'(1);
        if (chunk_end && scat_q)
            stride = ADDR_W'(1) + {{(ADDR_W-GAP_W){1'b0}}, gap};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            inc_q  <= 1'b0;
            scat_q <= 1'b0;
        end else if (load) begin
            addr_q <= base;
            inc_q  <= inc;
            scat_q <= scat;
        end else if (step && inc_q) begin
            addr_q <= addr_q + stride;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/ilv_walk_ctrl.sv
module ilv_walk_ctrl
    import ilv_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int LEN_W   = 8,
    parameter int FRAME_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] num_frames,
    input  logic [CNT_W-1:0]   num_chunks,
    input  logic               any_zero,
    input  logic [LEN_W-1:0]   rd_len,
    input  logic               beat_ready,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               load,
    output logic               step,
    output logic               chunk_end,
    output logic               beat_valid,
    output logic               done,
    output logic               idle
);

    ilv_state_e state_q, state_d;

    logic [IDX_W-1:0]   idx_q;
    logic [LEN_W-1:0]   byte_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] nf_q;
    logic [CNT_W-1:0]   nc_q;
    logic [CNT_W-1:0]   nc_clamp;
    logic               nothing_to_do;
    logic               last_chunk;
    logic               last_frame;
    logic               final_beat;

    assign nc_clamp      = (num_chunks > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : num_chunks;
    assign nothing_to_do = (num_frames == '0) || (nc_clamp == '0) || any_zero;
    assign last_chunk    = (CNT_W'(idx_q) == nc_q - CNT_W'(1));
    assign last_frame    = (frame_q == nf_q - FRAME_W'(1));
    assign final_beat    = step && chunk_end && last_chunk && last_frame;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: GO, SKIP, LAST_BEAT, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = nothing_to_do ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (final_beat) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        beat_valid = 1'b0;
        done       = 1'b0;
        idle       = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle       = 1'b1;
            ST_RUN:    beat_valid = 1'b1;
            ST_FINISH: done       = 1'b1;
            default:   idle       = 1'b0;
        endcase
        load      = idle && start;
        step      = beat_valid && beat_ready;
        chunk_end = beat_valid && (byte_q == rd_len - LEN_W'(1));
        rd_idx    = idx_q;
    end

    // Walk counters: byte within chunk, chunk within frame, frame within transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            byte_q  <= '0;
            frame_q <= '0;
            nf_q    <= '0;
            nc_q    <= '0;
        end else if (load) begin
            idx_q   <= '0;
            byte_q  <= '0;
            frame_q <= '0;
            nf_q    <= num_frames;
            nc_q    <= nc_clamp;
        end else if (step) begin
            if (chunk_end) begin
                byte_q <= '0;
                if (last_chunk) begin
                    idx_q   <= '0;
                    frame_q <= frame_q + FRAME_W'(1);
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end else begin
                byte_q <= byte_q + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 8,
    parameter int GAP_W   = 8,
    parameter int FRAME_W = 8,
    parameter int DEPTH   = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [LEN_W-1:0]   tbl_len,
    input  logic [GAP_W-1:0]   tbl_gap,
    input  logic               start,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic [FRAME_W-1:0] num_frames,
    input  logic [CNT_W-1:0]   num_chunks,
    input  logic               src_inc,
    input  logic               dst_inc,
    input  logic               src_scat,
    input  logic               dst_scat,
    output logic               beat_valid,
    input  logic               beat_ready,
    output logic [ADDR_W-1:0]  beat_src,
    output logic [ADDR_W-1:0]  beat_dst,
    output logic               done
);

    logic [IDX_W-1:0] rd_idx;
    logic [LEN_W-1:0] rd_len;
    logic [GAP_W-1:0] rd_gap;
    logic             any_zero;
    logic             load;
    logic             step;
    logic             chunk_end;
    logic             idle;
    logic             src_inc_q, src_scat_q, dst_inc_q, dst_scat_q;

    ilv_chunk_table #(.DEPTH(DEPTH), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we && idle),
        .wr_idx   (tbl_idx),
        .wr_len   (tbl_len),
        .wr_gap   (tbl_gap),
        .rd_idx   (rd_idx),
        .used_cnt (num_chunks),
        .rd_len   (rd_len),
        .rd_gap   (rd_gap),
        .any_zero (any_zero)
    );

    ilv_walk_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .FRAME_W(FRAME_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .num_frames (num_frames),
        .num_chunks (num_chunks),
        .any_zero   (any_zero),
        .rd_len     (rd_len),
        .beat_ready (beat_ready),
        .rd_idx     (rd_idx),
        .load       (load),
        .step       (step),
        .chunk_end  (chunk_end),
        .beat_valid (beat_valid),
        .done       (done),
        .idle       (idle)
    );

    ilv_addr_side #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (src_base),
        .inc       (src_inc),
        .scat      (src_scat),
        .step      (step),
        .chunk_end (chunk_end),
        .gap       (rd_gap),
        .addr      (beat_src),
        .inc_q     (src_inc_q),
        .scat_q    (src_scat_q)
    );

    ilv_addr_side #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (dst_base),
        .inc       (dst_inc),
        .scat      (dst_scat),
        .step      (step),
        .chunk_end (chunk_end),
        .gap       (rd_gap),
        .addr      (beat_dst),
        .inc_q     (dst_inc_q),
        .scat_q    (dst_scat_q)
    );

endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_src,
    input logic [ADDR_W-1:0] beat_dst,
    input logic              done,
    input logic              chunk_end,
    input logic              src_inc_q,
    input logic              src_scat_q,
    input logic              dst_inc_q
);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_src) && $stable(beat_dst)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !beat_valid));

    p_done_no_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid);

    p_src_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !src_inc_q) |=> $stable(beat_src));

    p_dst_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !dst_inc_q) |=> $stable(beat_dst));

    p_src_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !chunk_end && src_inc_q) |=> (beat_src == $past(beat_src) + 1'b1));

    p_src_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && chunk_end && src_inc_q && !src_scat_q) |=> (beat_src == $past(beat_src) + 1'b1));

endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_src   (beat_src),
    .beat_dst   (beat_dst),
    .done       (done),
    .chunk_end  (chunk_end),
    .src_inc_q  (src_inc_q),
    .src_scat_q (src_scat_q),
    .dst_inc_q  (dst_inc_q)
);

// File: tb/sim_ilv_addr_gen.sv
module sim_ilv_addr_gen;

    localparam int AW = 32;
    localparam int NV = 8;

    // Vector: {frames[3:0], chunks[2:0], {si,di,ss,ds}, len0..len3 (4b each), gap0..gap3 (4b each)}
    localparam logic [42:0] VEC [NV] = '{
        {4'd2, 3'd3, 4'b1111, 4'd3, 4'd1, 4'd2, 4'd0, 4'd2, 4'd5, 4'd1, 4'd0},
        {4'd1, 3'd2, 4'b1100, 4'd4, 4'd2, 4'd0, 4'd0, 4'd7, 4'd3, 4'd0, 4'd0},
        {4'd3, 3'd1, 4'b0111, 4'd2, 4'd0, 4'd0, 4'd0, 4'd4, 4'd0, 4'd0, 4'd0},
        {4'd2, 3'd4, 4'b1110, 4'd1, 4'd2, 4'd1, 4'd3, 4'd0, 4'd3, 4'd6, 4'd1},
        {4'd0, 3'd2, 4'b1111, 4'd2, 4'd2, 4'd0, 4'd0, 4'd1, 4'd1, 4'd0, 4'd0},
        {4'd2, 3'd0, 4'b1111, 4'd2, 4'd2, 4'd0, 4'd0, 4'd1, 4'd1, 4'd0, 4'd0},
        {4'd1, 3'd3, 4'b1111, 4'd2, 4'd0, 4'd3, 4'd0, 4'd1, 4'd1, 4'd1, 4'd0},
        {4'd1, 3'd4, 4'b0011, 4'd2, 4'd2, 4'd1, 4'd1, 4'd5, 4'd5, 4'd5, 4'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [1:0]    tbl_idx = '0;
    logic [7:0]    tbl_len = '0;
    logic [7:0]    tbl_gap = '0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] dst_base = '0;
    logic [7:0]    num_frames = '0;
    logic [2:0]    num_chunks = '0;
    logic          src_inc = 1'b0, dst_inc = 1'b0, src_scat = 1'b0, dst_scat = 1'b0;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [AW-1:0] beat_src, beat_dst;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] lfsr = 8'hA5;
    int sh_len [4];
    int sh_gap [4];

    always #10 clk = ~clk;

    ilv_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_len(tbl_len),
        .tbl_gap(tbl_gap), .start(start), .src_base(src_base), .dst_base(dst_base),
        .num_frames(num_frames), .num_chunks(num_chunks), .src_inc(src_inc), .dst_inc(dst_inc),
        .src_scat(src_scat), .dst_scat(dst_scat), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_src(beat_src), .beat_dst(beat_dst), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_entry(input int idx, input int len, input int gap);
        @(negedge clk);
        tbl_we  = 1'b1;
        tbl_idx = 2'(idx);
        tbl_len = 8'(len);
        tbl_gap = 8'(gap);
        sh_len[idx] = len;
        sh_gap[idx] = gap;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // One transfer: optional table load, optional mid-run disturbance, checked against a model.
    task automatic run_vec(input int v, input bit do_load, input bit disturb,
                           input logic [AW-1:0] sb, input logic [AW-1:0] db);
        logic [42:0] w;
        int nf, nc, total, seen, f, c, b;
        bit si, di, ss, ds, zero, fin, dist_on;
        logic [AW-1:0] es, ed;
        w  = VEC[v];
        nf = int'(w[42:39]);
        nc = int'(w[38:36]);
        {si, di, ss, ds} = w[35:32];
        if (do_load)
            for (int i = 0; i < 4; i++)
                write_entry(i, int'(w[31-4*i -: 4]), int'(w[15-4*i -: 4]));
        total = 0;
        zero  = (nf == 0) || (nc == 0);
        for (int i = 0; i < nc; i++) begin
            total += sh_len[i];
            if (sh_len[i] == 0) zero = 1'b1;
        end
        total = zero ? 0 : total * nf;
        @(negedge clk);
        start = 1'b1; src_base = sb; dst_base = db;
        num_frames = 8'(nf); num_chunks = 3'(nc);
        src_inc = si; dst_inc = di; src_scat = ss; dst_scat = ds;
        @(negedge clk);
        start = 1'b0;
        f = 0; c = 0; b = 0; es = sb; ed = db; seen = 0; fin = 1'b0; dist_on = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (dist_on) begin
                start = 1'b0; tbl_we = 1'b0; dist_on = 1'b0;
            end
            if (done) begin
                fin = 1'b1;
                check(seen == total, "R7 R10 beat count", AW'(seen), AW'(total));
                break;
            end
            if (beat_valid) begin
                check(seen < total, "R10 unexpected beat", AW'(seen), AW'(total));
                check(beat_src == es, seen == 0 ? "R2 src first" : "R3 R4 R5 R6 R8 R11 src",
                      beat_src, es);
                check(beat_dst == ed, seen == 0 ? "R2 dst first" : "R3 R4 R5 R6 R8 R11 dst",
                      beat_dst, ed);
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            beat_ready = lfsr[0] | lfsr[1];
            if (disturb && seen == 2 && beat_valid && !dist_on) begin
                start = 1'b1; src_base = 32'hDEAD_0000; dst_base = 32'hBEEF_0000;
                tbl_we = 1'b1; tbl_idx = 2'd0; tbl_len = 8'd9; tbl_gap = 8'd9;
                dist_on = 1'b1;
                disturb = 1'b0;
            end
            if (beat_valid && beat_ready) begin
                seen++;
                b++;
                if (b == sh_len[c]) begin
                    es += si ? AW'(1 + (ss ? sh_gap[c] : 0)) : '0;
                    ed += di ? AW'(1 + (ds ? sh_gap[c] : 0)) : '0;
                    b = 0; c++;
                    if (c == nc) begin c = 0; f++; end
                end else begin
                    es += si ? AW'(1) : '0;
                    ed += di ? AW'(1) : '0;
                end
            end
            @(negedge clk);
        end
        beat_ready = 1'b0; start = 1'b0; tbl_we = 1'b0;
        check(fin, "R9 done seen (watchdog)", AW'(fin), 1);
        @(negedge clk);
        check(!done && !beat_valid, "R9 single pulse then idle", {done, beat_valid}, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin sh_len[i] = 0; sh_gap[i] = 0; end
        repeat (3) @(negedge clk);
        check(!beat_valid && !done, "R1 during reset", {beat_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!beat_valid && !done, "R1 after reset", {beat_valid, done}, 0);

        for (int v = 0; v < NV; v++)
            run_vec(v, 1'b1, 1'b0, 32'h1000 + 32'(v * 256), 32'h8000 + 32'(v * 512));

        // R11: start and table write in mid-run, then a rerun of the same table without reload
        run_vec(0, 1'b1, 1'b1, 32'h0000_4000, 32'h0000_6000);
        run_vec(0, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_7000);

        // R8: long stall on the first beat, addresses must hold
        write_entry(0, 2, 3);
        @(negedge clk);
        start = 1'b1; src_base = 32'h300; dst_base = 32'h400;
        num_frames = 8'd1; num_chunks = 3'd1;
        src_inc = 1'b1; dst_inc = 1'b1; src_scat = 1'b1; dst_scat = 1'b1;
        beat_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(beat_valid && beat_src == 32'h300, "R8 src held", beat_src, 32'h300);
        check(beat_dst == 32'h400, "R8 dst held", beat_dst, 32'h400);
        beat_ready = 1'b1;
        @(negedge clk);
        check(beat_src == 32'h301, "R3 src after stall", beat_src, 32'h301);
        @(negedge clk);
        beat_ready = 1'b0;
        check(done && !beat_valid, "R9 done after final beat", {done, beat_valid}, 2'b10);
        @(negedge clk);
        check(!done, "R9 done one cycle", AW'(done), 0);

        // R7: chunk count above table depth is clamped to the depth
        for (int i = 0; i < 4; i++) write_entry(i, 1, 0);
        @(negedge clk);
        start = 1'b1; src_base = 32'h0; dst_base = 32'h0;
        num_frames = 8'd1; num_chunks = 3'd7;
        beat_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int cnt = 0;
            for (int k = 0; k < 20; k++) begin
                if (done) break;
                if (beat_valid) cnt++;
                @(negedge clk);
            end
            check(cnt == 4, "R7 clamp count", AW'(cnt), 4);
        end
        beat_ready = 1'b0;
        repeat (2) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule